// File: doc/BRIEF.md
# Vectored Interrupt Front End

This block sits between a set of peripheral interrupt lines and a microsequenced processor core. Every raw request line is brought into the processor clock domain by a two-flop synchronizer. Software can enable or disable each line through a mask register. The surviving requests are ranked by a fixed priority, and the block presents the winner as a registered request flag, a one-hot select word and a vectored service address. Each source branches to its own address.

When the core takes the interrupt it pulses `ack_i`. The block then stores the index of the source being served and suppresses that source, so it cannot win again until the core pulses `ret_i`. Only one service level is tracked. A new acknowledge is accepted only when no service is open, or in the same cycle as the return that closes the open one.

Top module: `intc_vector_top`

## Requirements
- R1: A request change on `req_async_i` shows on `irq_o`/`sel_o` at the third rising clock edge after it is applied, and not earlier (two synchronizer stages plus the output register).
- R2: After reset the mask is all zero, which means all sources are disabled. While `mask_we_i` is high, `mask_wdata_i` is loaded at the clock edge, and bit k = 1 enables source k. While `mask_we_i` is low, `mask_wdata_i` has no effect.
- R3: `irq_o` is high exactly when at least one synchronized request is enabled and not in service.
- R4: `sel_o` is one-hot and marks the eligible source with the lowest index. Index 0 has the highest priority.
- R5: While `irq_o` is high, `vec_o` = `VEC_BASE` + (winning index << `VEC_SHIFT`). While it is low, `vec_o` = `VEC_BASE` and `sel_o` = 0.
- R6: An `ack_i` pulse while `irq_o` is high and no service is open does four things at that edge: it loads the presented index into `svc_id_o`, sets `svc_active_o`, inhibits that source, and updates `irq_o`/`sel_o`/`vec_o` to reflect the inhibit.
- R7: `ack_i` is ignored while `irq_o` is low, and also while a service is open unless `ret_i` is high in the same cycle.
- R8: A `ret_i` pulse releases the inhibit of `svc_id_o` and clears `svc_active_o`. If `ret_i` and `ack_i` arrive together, the old source is released and the presented one is taken at the same edge.
- R9: While `rst` is high, `irq_o`, `sel_o`, `svc_active_o` and `svc_id_o` are 0 and `vec_o` is `VEC_BASE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | processor clock |
| rst | input | 1 | synchronous active-high reset |
| req_async_i | input | NUM_SRC | raw device requests, asynchronous |
| mask_we_i | input | 1 | mask register write enable |
| mask_wdata_i | input | NUM_SRC | new mask value, 1 = enabled |
| ack_i | input | 1 | core takes the presented interrupt |
| ret_i | input | 1 | core finished the open service |
| irq_o | output | 1 | an eligible request is pending |
| sel_o | output | NUM_SRC | one-hot select of the winning source |
| vec_o | output | VEC_W | service address of the winner |
| svc_id_o | output | $clog2(NUM_SRC) | index of the source in service |
| svc_active_o | output | 1 | a service is open |

## Verification
Return and acknowledge can land in the same cycle. When they do, the closing service releases its source while the next winner is taken at the very same edge. The bench provokes this with all sources requesting and enabled. Source 0 is in service and source 1 is presented when both pulses are applied together. The result is judged at the ports: `svc_id_o` must move to 1, `svc_active_o` must stay high, and `sel_o`/`vec_o` must return to source 0 at once. An acknowledge without the return, issued while busy, must leave every output unchanged.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic {SVC_IDLE = 1'b0, SVC_BUSY = 1'b1} svc_state_e;

  function automatic int unsigned id_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1_q[k] <= 1'b0;
        stage2_q[k] <= 1'b0;
      end else begin
        stage1_q[k] <= async_i[k];
        stage2_q[k] <= stage1_q[k];
      end
    end
  end

  assign sync_o = stage2_q;

  // R1: second stage follows first stage one cycle later
  assert_two_stage_R1: assert property (@(posedge clk) disable iff (rst)
    stage2_q == $past(stage1_q));
endmodule

// File: rtl/intc_mask.sv
module intc_mask #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o
);
  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  // R2: no write, no change
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_q));
  // R2: a write lands
  assert_mask_load_R2: assert property (@(posedge clk) disable iff (rst)
    we_i |=> mask_q == $past(wdata_i));
endmodule

// File: rtl/intc_rank.sv
module intc_rank #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDW   = 3
) (
  input  logic [WIDTH-1:0] elig_i,
  output logic             any_o,
  output logic [IDW-1:0]   id_o,
  output logic [WIDTH-1:0] onehot_o
);
  always_comb begin
    any_o    = 1'b0;
    id_o     = '0;
    onehot_o = '0;
    for (int k = WIDTH - 1; k >= 0; k--) begin
      if (elig_i[k]) begin
        any_o    = 1'b1;
        id_o     = IDW'(k);
        onehot_o = WIDTH'(1) << k;
      end
    end
  end
endmodule

// File: rtl/intc_vector_top.sv
module intc_vector_top #(
  parameter int unsigned NUM_SRC   = 8,
  parameter int unsigned VEC_W     = 12,
  parameter int unsigned VEC_BASE  = 'h100,
  parameter int unsigned VEC_SHIFT = 4,
  localparam int unsigned IDW      = intc_pkg::id_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_async_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] sel_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [IDW-1:0]     svc_id_o,
  output logic               svc_active_o
);
  import intc_pkg::*;

  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);

  logic [NUM_SRC-1:0] req_sync;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] isr_q, isr_d;
  logic [NUM_SRC-1:0] elig;
  logic               rank_any;
  logic [IDW-1:0]     rank_id;
  logic [NUM_SRC-1:0] rank_oh;

  logic               irq_q;
  logic [NUM_SRC-1:0] sel_q;
  logic [VEC_W-1:0]   vec_q;
  logic [IDW-1:0]     win_id_q;
  logic [IDW-1:0]     svc_id_q;
  svc_state_e         state_q, state_d;
  logic               ack_ok;
  logic               ret_ok;

  intc_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rst(rst), .async_i(req_async_i), .sync_o(req_sync)
  );

  intc_mask #(.WIDTH(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .we_i(mask_we_i), .wdata_i(mask_wdata_i), .mask_o(mask_q)
  );

  // handshake
  assign ret_ok = ret_i && (state_q == SVC_BUSY);
  assign ack_ok = ack_i && irq_q && ((state_q == SVC_IDLE) || ret_i);

  always_comb begin
    isr_d = isr_q;
    if (ret_ok) isr_d[svc_id_q] = 1'b0;
    if (ack_ok) isr_d[win_id_q] = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    if (ack_ok)      state_d = SVC_BUSY;
    else if (ret_ok) state_d = SVC_IDLE;
  end

  // ranking uses next inhibit so a taken source never lingers on the outputs
  assign elig = req_sync & mask_q & ~isr_d;

  intc_rank #(.WIDTH(NUM_SRC), .IDW(IDW)) u_rank (
    .elig_i(elig), .any_o(rank_any), .id_o(rank_id), .onehot_o(rank_oh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q    <= '0;
      state_q  <= SVC_IDLE;
      svc_id_q <= '0;
      irq_q    <= 1'b0;
      sel_q    <= '0;
      vec_q    <= BASE_V;
      win_id_q <= '0;
    end else begin
      isr_q    <= isr_d;
      state_q  <= state_d;
      if (ack_ok) svc_id_q <= win_id_q;
      irq_q    <= rank_any;
      sel_q    <= rank_oh;
      win_id_q <= rank_id;
      vec_q    <= BASE_V + (VEC_W'(rank_id) << VEC_SHIFT);
    end
  end

  assign irq_o        = irq_q;
  assign sel_o        = sel_q;
  assign vec_o        = vec_q;
  assign svc_id_o     = svc_id_q;
  assign svc_active_o = (state_q == SVC_BUSY);

  // R4: at most one select bit
  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));
  // R3/R5: request flag agrees with the select word and its index
  assert_irq_sel_R3: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> sel_o[win_id_q]);
  // R6: source in service never presented
  assert_inhibit_R6: assert property (@(posedge clk) disable iff (rst)
    svc_active_o |-> !sel_o[svc_id_o]);
  // R6: accepted acknowledge opens service for presented index
  assert_ack_take_R6: assert property (@(posedge clk) disable iff (rst)
    ack_ok |=> svc_active_o && (svc_id_o == $past(win_id_q)));
  // R7: busy acknowledge without return changes nothing
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_i && svc_active_o && !ret_i) |=> $stable(svc_id_o) && svc_active_o);
  // R8: lone return closes the service
  assert_ret_close_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !ack_i) |=> !svc_active_o);
endmodule

// File: tb/test_intc_vector_top.sv
module test_intc_vector_top;
  localparam int unsigned N     = 8;
  localparam int unsigned VW    = 12;
  localparam int unsigned BASE  = 'h100;
  localparam int unsigned SH    = 4;
  localparam int unsigned IDW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0;
  logic mwe = 1'b0;
  logic [N-1:0] mwd = '0;
  logic ack = 1'b0, ret = 1'b0;
  logic irq;
  logic [N-1:0] sel;
  logic [VW-1:0] vec;
  logic [IDW-1:0] sid;
  logic act;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intc_vector_top #(.NUM_SRC(N), .VEC_W(VW), .VEC_BASE(BASE), .VEC_SHIFT(SH)) i_intc_vector_top (
    .clk(clk), .rst(rst), .req_async_i(req), .mask_we_i(mwe), .mask_wdata_i(mwd),
    .ack_i(ack), .ret_i(ret), .irq_o(irq), .sel_o(sel), .vec_o(vec),
    .svc_id_o(sid), .svc_active_o(act)
  );

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", r, got, exp);
    end
  endtask

  // expected outputs from an eligible pattern
  task automatic chk_out(input string r, input logic [N-1:0] e);
    logic any = 1'b0;
    int idx = 0;
    for (int k = N - 1; k >= 0; k--) if (e[k]) begin any = 1'b1; idx = k; end
    chk({r, " irq"}, 32'(irq), 32'(any));
    chk({r, " sel"}, 32'(sel), any ? (32'd1 << idx) : 32'd0);
    chk({r, " vec"}, 32'(vec), any ? BASE + (idx << SH) : BASE);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mask(input logic [N-1:0] m);
    mwe = 1'b1; mwd = m; cyc(1); mwe = 1'b0; mwd = ~m;
  endtask

  task automatic pulse(input logic a, input logic r);
    ack = a; ret = r; cyc(1); ack = 1'b0; ret = 1'b0;
  endtask

  initial begin
    cyc(3);
    // R9 reset state
    chk("R9 irq", 32'(irq), 0); chk("R9 sel", 32'(sel), 0);
    chk("R9 vec", 32'(vec), BASE); chk("R9 act", 32'(act), 0); chk("R9 id", 32'(sid), 0);
    rst = 1'b0;
    cyc(1);
    // R2 reset mask disables everything
    req = '1; cyc(4);
    chk_out("R2 reset mask", '0);
    // R7 ack with irq low ignored
    pulse(1'b1, 1'b0);
    chk("R7 idle ack act", 32'(act), 0);
    req = '0; cyc(4);
    // R1 latency
    set_mask('1);
    cyc(2);
    req = 8'h20;
    cyc(2); chk("R1 two edges", 32'(irq), 0);
    cyc(1); chk("R1 three edges", 32'(irq), 1);
    // R3 R4 R5 sweep over masks and all request patterns
    for (int mi = 0; mi < 4; mi++) begin
      logic [N-1:0] m;
      m = (mi == 0) ? 8'hFF : (mi == 1) ? 8'h5A : (mi == 2) ? 8'hF0 : 8'h81;
      set_mask(m);
      for (int p = 0; p < 256; p++) begin
        req = 8'(p);
        cyc(3);
        chk_out("R4 R5 R3 sweep", 8'(p) & m);
      end
    end
    // R2 write enable low ignores data
    set_mask(8'h0C); req = 8'hFF; cyc(3);
    mwd = 8'hFF; cyc(3);
    chk_out("R2 no we", 8'h0C);
    set_mask('1); cyc(3);
    // R6 accept
    pulse(1'b1, 1'b0);
    chk("R6 act", 32'(act), 1); chk("R6 id", 32'(sid), 0);
    chk_out("R6 inhibit", 8'hFE);
    // R7 busy ack ignored
    pulse(1'b1, 1'b0);
    chk("R7 busy id", 32'(sid), 0); chk("R7 busy act", 32'(act), 1);
    chk_out("R7 busy", 8'hFE);
    // R8 ret and ack same cycle
    pulse(1'b1, 1'b1);
    chk("R8 both id", 32'(sid), 1); chk("R8 both act", 32'(act), 1);
    chk_out("R8 both", 8'hFD);
    // R8 lone ret
    pulse(1'b0, 1'b1);
    chk("R8 ret act", 32'(act), 0);
    chk_out("R8 ret", 8'hFF);
    // R6 take again after release, then masked-only source path
    set_mask(8'h40); cyc(2);
    pulse(1'b1, 1'b0);
    chk("R6 id6", 32'(sid), 6);
    chk_out("R6 only src inhibited", 8'h00);
    pulse(1'b0, 1'b1);
    chk_out("R8 release src6", 8'h40);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule